// File: doc/BRIEF.md
# Recency-Managed Address Translation Cache

This block is a small fully associative cache of address translations placed ahead of a page-table walker. Each of its sixteen slots maps a key made of an 18-bit segment number and a 6-bit virtual page number to an 18-bit page frame and three permission bits. A lookup compares the key against every slot at once and returns its result in the same cycle. On a permitted hit the physical address is the stored frame with the request offset appended, so no descriptor or page table is read. On a miss the block raises `lk_miss` so that the walker can start. The walker later writes the translation in through the fill port.

Both the lookup port and the fill port follow valid/ready rules. A lookup counts as accepted only in a cycle where `lk_valid` and `lk_ready` are both high, and its result outputs mean something only in that cycle. `lk_ready` drops whenever a fill is offered or a flush is asserted, so a fill always wins over a concurrent lookup. `fill_ready` drops only while `flush` is high. A requester that is held off keeps its request stable until it sees ready.

Replacement is true least-recently-used over all sixteen slots. An accepted lookup that finds its key, and every accepted fill, moves the slot used to the most-recent position. A set of up to sixteen active pages therefore stays resident.

Top module: `xlat_tlb`

## Requirements
- R1: A translation written by an accepted fill is found (hit or fault, never miss) by any accepted lookup with the same segment and page in a later cycle, until it is evicted or flushed.
- R2: In a cycle with an accepted lookup, exactly one of `lk_hit`, `lk_miss`, `lk_fault` is high, decided combinationally in that cycle. With no accepted lookup, all three are low.
- R3: On `lk_hit`, `lk_paddr` equals the stored 18-bit frame in the upper bits with the 10-bit request offset in the lower bits. Otherwise `lk_paddr` is zero.
- R4: Sixteen fills with distinct keys after a flush leave all sixteen translations resident, and each one then hits with its own frame.
- R5: A fill of a new key when all slots are valid replaces the least recently referenced slot. Referencing means an accepted fill or an accepted lookup that finds the key. Lookups that miss do not change the order.
- R6: Permission bit 0 allows reads, bit 1 allows writes and bit 2 allows execution. `lk_acc` codes are 0 = read, 1 = write, 2 = execute, and 3 = reserved, which is always denied. A found key whose access is denied raises `lk_fault` with `lk_paddr` zero.
- R7: A cycle with `flush` high invalidates every slot, so lookups from the next cycle onward miss.
- R8: While `fill_valid` is high, `lk_ready` is low and no lookup is accepted, so the fill is taken first.
- R9: A fill whose key is already resident rewrites that slot in place. No duplicate is made, no other slot is evicted, and later hits return the new frame.
- R10: While `flush` is high, `fill_ready` and `lk_ready` are both low, and a fill offered in that cycle is not written.
- R11: After reset every slot is invalid and every accepted lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate all slots this cycle |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_seg | input | 18 | Segment number of the lookup |
| lk_vpn | input | 6 | Virtual page number of the lookup |
| lk_off | input | 10 | Word offset within the page |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Key found and access permitted |
| lk_miss | output | 1 | Key not resident; walker should fetch it |
| lk_fault | output | 1 | Key found but access denied |
| lk_paddr | output | 28 | Physical address on a hit, zero otherwise |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_seg | input | 18 | Segment number of the new translation |
| fill_vpn | input | 6 | Virtual page number of the new translation |
| fill_frame | input | 18 | Page frame of the new translation |
| fill_prot | input | 3 | Permission bits of the new translation |

## Verification
The hardest state to reach from the ports is a full cache whose recency order has been reshuffled by a mix of hits and fills, because eviction choices only show up indirectly, as which keys later miss. The stimulus flushes and fills all sixteen slots in a known order, then references chosen keys to move the least-recent position. It adds new keys and probes which old keys still hit. Because probing is itself a reference, the expected order is recomputed after each probe, so that the second eviction is also predicted. Same-cycle collisions of fill with lookup, and of flush with fill, are driven in a single cycle and observed through the ready signals and a following lookup.

// File: rtl/xlat_tlb_pkg.sv
`timescale 1ns/1ps
package xlat_tlb_pkg;
  localparam int PROT_W = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // permission bit 0 read, 1 write, 2 execute; reserved code never allowed
  function automatic logic acc_allowed(input logic [PROT_W-1:0] prot, input acc_e acc);
    case (acc)
      ACC_READ:  return prot[0];
      ACC_WRITE: return prot[1];
      ACC_EXEC:  return prot[2];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xlat_tlb_match.sv
`timescale 1ns/1ps
module xlat_tlb_match #(
  parameter int N     = 16,
  parameter int KEY_W = 24,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][KEY_W-1:0] keys,
  input  logic [KEY_W-1:0]        probe,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] hitv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hitv[g] = valid[g] && (keys[g] == probe);
  end

  assign found = |hitv;

  // at most one slot matches, so an OR of indices is the encoder
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hitv[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_tlb_store.sv
`timescale 1ns/1ps
module xlat_tlb_store #(
  parameter int N       = 16,
  parameter int KEY_W   = 24,
  parameter int FRAME_W = 18,
  parameter int PROT_W  = 3,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [KEY_W-1:0]          wkey,
  input  logic [FRAME_W-1:0]        wframe,
  input  logic [PROT_W-1:0]         wprot,
  output logic [N-1:0]              valid,
  output logic [N-1:0][KEY_W-1:0]   keys,
  output logic [N-1:0][FRAME_W-1:0] frames,
  output logic [N-1:0][PROT_W-1:0]  prots
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid <= '0;
    end else if (we) begin
      valid[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !clear) begin
      keys[widx]   <= wkey;
      frames[widx] <= wframe;
      prots[widx]  <= wprot;
    end
  end
endmodule

// File: rtl/xlat_tlb_lru.sv
`timescale 1ns/1ps
module xlat_tlb_lru #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest
);
  // order[0] is most recent, order[N-1] least recent
  logic [N-1:0][IDX_W-1:0] order, order_nxt;
  logic [N-1:0]            at;

  for (genvar g = 0; g < N; g++) begin : g_pos
    assign at[g] = (order[g] == touch_idx);
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    order_nxt = order;
    for (int i = N-1; i >= 1; i--) begin
      seen = seen | at[i];
      if (seen) order_nxt[i] = order[i-1];
    end
    order_nxt[0] = touch_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) order[i] <= IDX_W'(i);
    end else if (touch_en) begin
      order <= order_nxt;
    end
  end

  assign oldest = order[N-1];
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb #(
  parameter int ENTRIES = 16,
  parameter int SEG_W   = 18,
  parameter int VPN_W   = 6,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [SEG_W-1:0]         lk_seg,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [OFF_W-1:0]         lk_off,
  input  logic [1:0]               lk_acc,
  output logic                     lk_hit,
  output logic                     lk_miss,
  output logic                     lk_fault,
  output logic [FRAME_W+OFF_W-1:0] lk_paddr,
  input  logic                     fill_valid,
  output logic                     fill_ready,
  input  logic [SEG_W-1:0]         fill_seg,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [FRAME_W-1:0]       fill_frame,
  input  logic [2:0]               fill_prot
);
  import xlat_tlb_pkg::*;

  localparam int KEY_W = SEG_W + VPN_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              valid;
  logic [ENTRIES-1:0][KEY_W-1:0]   keys;
  logic [ENTRIES-1:0][FRAME_W-1:0] frames;
  logic [ENTRIES-1:0][PROT_W-1:0]  prots;

  logic             lk_go, fill_go;
  logic             lk_found, fill_found, any_free;
  logic [IDX_W-1:0] lk_idx, fill_idx, free_idx, oldest, victim;
  logic             permit;
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;

  // handshake: flush blocks both ports, a fill blocks lookups
  assign fill_ready = !flush;
  assign lk_ready   = !flush && !fill_valid;
  assign fill_go    = fill_valid && fill_ready;
  assign lk_go      = lk_valid && lk_ready;

  xlat_tlb_match #(.N(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_lk_match (
    .valid(valid), .keys(keys), .probe({lk_seg, lk_vpn}),
    .found(lk_found), .idx(lk_idx)
  );

  xlat_tlb_match #(.N(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_fill_match (
    .valid(valid), .keys(keys), .probe({fill_seg, fill_vpn}),
    .found(fill_found), .idx(fill_idx)
  );

  // lowest-numbered free slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (fill_found)    victim = fill_idx;
    else if (any_free) victim = free_idx;
    else               victim = oldest;
  end

  assign permit   = acc_allowed(prots[lk_idx], acc_e'(lk_acc));
  assign lk_hit   = lk_go && lk_found && permit;
  assign lk_fault = lk_go && lk_found && !permit;
  assign lk_miss  = lk_go && !lk_found;
  assign lk_paddr = lk_hit ? {frames[lk_idx], lk_off} : '0;

  assign touch_en  = fill_go || (lk_go && lk_found);
  assign touch_idx = fill_go ? victim : lk_idx;

  xlat_tlb_store #(
    .N(ENTRIES), .KEY_W(KEY_W), .FRAME_W(FRAME_W), .PROT_W(PROT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .clear(flush),
    .we(fill_go), .widx(victim), .wkey({fill_seg, fill_vpn}),
    .wframe(fill_frame), .wprot(fill_prot),
    .valid(valid), .keys(keys), .frames(frames), .prots(prots)
  );

  xlat_tlb_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en && !flush), .touch_idx(touch_idx),
    .oldest(oldest)
  );
endmodule

// File: rtl/xlat_tlb_chk.sv
`timescale 1ns/1ps
module xlat_tlb_chk #(
  parameter int SEG_W   = 18,
  parameter int VPN_W   = 6,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 18
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     flush,
  input logic                     lk_valid,
  input logic                     lk_ready,
  input logic [SEG_W-1:0]         lk_seg,
  input logic [VPN_W-1:0]         lk_vpn,
  input logic [OFF_W-1:0]         lk_off,
  input logic                     lk_hit,
  input logic                     lk_miss,
  input logic                     lk_fault,
  input logic [FRAME_W+OFF_W-1:0] lk_paddr,
  input logic                     fill_valid,
  input logic                     fill_ready,
  input logic [SEG_W-1:0]         fill_seg,
  input logic [VPN_W-1:0]         fill_vpn
);
  assert_fill_visible_R1: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && $past(fill_valid && fill_ready)
     && ({lk_seg, lk_vpn} == $past({fill_seg, fill_vpn}))) |-> !lk_miss);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_ready) |-> ({lk_hit, lk_miss, lk_fault} == 3'b000));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_off));

  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_paddr == '0));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!lk_hit && !lk_fault));

  assert_fill_first_R8: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !lk_ready);

  assert_flush_stalls_R10: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!fill_ready && !lk_ready));
endmodule

bind xlat_tlb xlat_tlb_chk #(
  .SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_seg(lk_seg), .lk_vpn(lk_vpn), .lk_off(lk_off),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
  .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_seg(fill_seg), .fill_vpn(fill_vpn)
);

// File: tb/xlat_tlb_bench.sv
`timescale 1ns/1ps
module xlat_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [17:0] lk_seg = '0;
  logic [5:0]  lk_vpn = '0;
  logic [9:0]  lk_off = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [27:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [17:0] fill_seg = '0;
  logic [5:0]  fill_vpn = '0;
  logic [17:0] fill_frame = '0;
  logic [2:0]  fill_prot = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic        s_hit, s_miss, s_fault, s_lkr;
  logic [27:0] s_paddr;

  always #2 clk = ~clk;

  xlat_tlb u_xlat_tlb (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_seg(lk_seg), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_seg(fill_seg), .fill_vpn(fill_vpn),
    .fill_frame(fill_frame), .fill_prot(fill_prot)
  );

  function automatic logic [17:0] seg_of(input int i);
    return 18'(32'h100 + i * 7);
  endfunction
  function automatic logic [5:0] vpn_of(input int i);
    return 6'(i * 3 + 1);
  endfunction
  function automatic logic [17:0] frm_of(input int i, input int base);
    return 18'(base + i * 5);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one-cycle lookup: drive at negedge, sample mid-cycle, commit at posedge
  task automatic do_lookup(input logic [17:0] s, input logic [5:0] v,
                           input logic [9:0] o, input logic [1:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_seg = s; lk_vpn = v; lk_off = o; lk_acc = a;
    #1;
    s_hit = lk_hit; s_miss = lk_miss; s_fault = lk_fault;
    s_paddr = lk_paddr; s_lkr = lk_ready;
    @(posedge clk); #0.5;
    lk_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [17:0] s, input logic [5:0] v,
                         input logic [17:0] f, input logic [2:0] p);
    @(negedge clk);
    fill_valid = 1'b1; fill_seg = s; fill_vpn = v; fill_frame = f; fill_prot = p;
    @(posedge clk); #0.5;
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #0.5;
    flush = 1'b0;
  endtask

  // kind: 4 = hit, 2 = miss, 1 = fault
  task automatic expect_lk(input logic [17:0] s, input logic [5:0] v, input logic [9:0] o,
                           input logic [1:0] a, input logic [2:0] kind,
                           input logic [17:0] frame, input string tag);
    logic [27:0] exp_pa;
    do_lookup(s, v, o, a);
    check({s_hit, s_miss, s_fault} == kind, tag, 64'({s_hit, s_miss, s_fault}), 64'(kind));
    exp_pa = (kind == 3'b100) ? {frame, o} : 28'h0;
    check(s_paddr == exp_pa, tag, 64'(s_paddr), 64'(exp_pa));
  endtask

  task automatic t_reset();
    check(lk_ready == 1'b1, "R11 ready after reset", 64'(lk_ready), 64'd1);
    check(fill_ready == 1'b1, "R11 fill ready after reset", 64'(fill_ready), 64'd1);
    expect_lk(seg_of(0), vpn_of(0), 10'h3, 2'd0, 3'b010, '0, "R11 empty lookup misses");
    expect_lk(18'h0, 6'h0, 10'h0, 2'd0, 3'b010, '0, "R11 zero key misses");
  endtask

  task automatic t_basic();
    do_fill(18'h2A5A5, 6'h3F, 18'h1F00F, 3'b111);
    expect_lk(18'h2A5A5, 6'h3F, 10'h2C7, 2'd0, 3'b100, 18'h1F00F, "R1 R3 read after fill");
    expect_lk(18'h2A5A5, 6'h3F, 10'h3FF, 2'd2, 3'b100, 18'h1F00F, "R3 exec max offset");
    expect_lk(18'h2A5A5, 6'h3E, 10'h001, 2'd0, 3'b010, '0, "R2 neighbour page misses");
    @(negedge clk); #1;
    check({lk_hit, lk_miss, lk_fault} == 3'b000, "R2 idle outputs low",
          64'({lk_hit, lk_miss, lk_fault}), 64'd0);
  endtask

  task automatic t_capacity();
    do_flush();
    for (int i = 0; i < 16; i++) do_fill(seg_of(i), vpn_of(i), frm_of(i, 'h300), 3'b001);
    for (int i = 0; i < 16; i++)
      expect_lk(seg_of(i), vpn_of(i), 10'(i * 17), 2'd0, 3'b100, frm_of(i, 'h300), "R4 all sixteen resident");
  endtask

  task automatic t_lru();
    do_flush();
    for (int i = 0; i < 16; i++) do_fill(seg_of(i), vpn_of(i), frm_of(i, 'h500), 3'b001);
    // key 0 is oldest; reference it so key 1 becomes oldest
    expect_lk(seg_of(0), vpn_of(0), 10'h5, 2'd0, 3'b100, frm_of(0, 'h500), "R5 touch oldest");
    do_fill(seg_of(16), vpn_of(16), frm_of(16, 'h500), 3'b001);
    expect_lk(seg_of(1), vpn_of(1), 10'h5, 2'd0, 3'b010, '0, "R5 least recent evicted");
    expect_lk(seg_of(0), vpn_of(0), 10'h6, 2'd0, 3'b100, frm_of(0, 'h500), "R5 touched key kept");
    expect_lk(seg_of(16), vpn_of(16), 10'h7, 2'd0, 3'b100, frm_of(16, 'h500), "R5 new key resident");
    expect_lk(seg_of(2), vpn_of(2), 10'h8, 2'd0, 3'b100, frm_of(2, 'h500), "R5 key2 kept");
    // now key 3 is oldest (miss on key 1 did not reorder)
    do_fill(seg_of(17), vpn_of(17), frm_of(17, 'h500), 3'b001);
    expect_lk(seg_of(3), vpn_of(3), 10'h9, 2'd0, 3'b010, '0, "R5 second eviction");
    expect_lk(seg_of(4), vpn_of(4), 10'hA, 2'd0, 3'b100, frm_of(4, 'h500), "R5 next oldest kept");
  endtask

  task automatic t_prot();
    do_fill(18'h00777, 6'h21, 18'h0ABCD, 3'b001);
    expect_lk(18'h00777, 6'h21, 10'h10, 2'd0, 3'b100, 18'h0ABCD, "R6 read allowed");
    expect_lk(18'h00777, 6'h21, 10'h10, 2'd1, 3'b001, '0, "R6 write denied");
    expect_lk(18'h00777, 6'h21, 10'h10, 2'd2, 3'b001, '0, "R6 exec denied");
    expect_lk(18'h00777, 6'h21, 10'h10, 2'd3, 3'b001, '0, "R6 reserved denied");
    do_fill(18'h00778, 6'h22, 18'h0BEEF, 3'b110);
    expect_lk(18'h00778, 6'h22, 10'h11, 2'd1, 3'b100, 18'h0BEEF, "R6 write allowed");
    expect_lk(18'h00778, 6'h22, 10'h11, 2'd0, 3'b001, '0, "R6 read denied");
  endtask

  task automatic t_dup();
    do_flush();
    for (int i = 0; i < 16; i++) do_fill(seg_of(i), vpn_of(i), frm_of(i, 'h900), 3'b011);
    do_fill(seg_of(5), vpn_of(5), 18'h3C3C3, 3'b011);
    for (int i = 0; i < 16; i++)
      expect_lk(seg_of(i), vpn_of(i), 10'h44, 2'd1, 3'b100,
                (i == 5) ? 18'h3C3C3 : frm_of(i, 'h900), "R9 rewrite in place");
  endtask

  task automatic t_flush();
    do_fill(seg_of(40), vpn_of(40), 18'h11111, 3'b111);
    do_flush();
    expect_lk(seg_of(40), vpn_of(40), 10'h1, 2'd0, 3'b010, '0, "R7 flushed key misses");
    expect_lk(seg_of(0), vpn_of(0), 10'h1, 2'd0, 3'b010, '0, "R7 older key misses");
  endtask

  task automatic t_priority();
    @(negedge clk);
    fill_valid = 1'b1; fill_seg = 18'h01234; fill_vpn = 6'h15;
    fill_frame = 18'h2468A; fill_prot = 3'b001;
    lk_valid = 1'b1; lk_seg = 18'h01234; lk_vpn = 6'h15; lk_off = 10'h0; lk_acc = 2'd0;
    #1;
    check(lk_ready == 1'b0, "R8 lookup held off", 64'(lk_ready), 64'd0);
    check({lk_hit, lk_miss, lk_fault} == 3'b000, "R8 no result while held",
          64'({lk_hit, lk_miss, lk_fault}), 64'd0);
    check(fill_ready == 1'b1, "R8 fill accepted", 64'(fill_ready), 64'd1);
    @(posedge clk); #0.5;
    fill_valid = 1'b0; lk_valid = 1'b0;
    expect_lk(18'h01234, 6'h15, 10'h2F, 2'd0, 3'b100, 18'h2468A, "R8 R1 held lookup then hits");
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_seg = 18'h35555; fill_vpn = 6'h0A;
    fill_frame = 18'h13579; fill_prot = 3'b111;
    lk_valid = 1'b1; lk_seg = 18'h01234; lk_vpn = 6'h15;
    #1;
    check(fill_ready == 1'b0, "R10 fill blocked by flush", 64'(fill_ready), 64'd0);
    check(lk_ready == 1'b0, "R10 lookup blocked by flush", 64'(lk_ready), 64'd0);
    @(posedge clk); #0.5;
    flush = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    expect_lk(18'h35555, 6'h0A, 10'h3, 2'd0, 3'b010, '0, "R10 blocked fill not written");
    expect_lk(18'h01234, 6'h15, 10'h3, 2'd0, 3'b010, '0, "R7 prior entry cleared");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    t_reset();
    t_basic();
    t_capacity();
    t_lru();
    t_prot();
    t_dup();
    t_flush();
    t_priority();
    t_flush_fill();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule